// File: doc/BRIEF.md
# Frame Supervision Timeout Timers

This block supervises the phases of an incoming radio frame with three independent timeout timers. The first timer watches the window from wake-up to the start of a frame. The second watches the frame's own length, from its start to its stop. The third watches the quiet period that follows a frame that ended with a good CRC. Frame detection happens elsewhere. This block only sees single-cycle event pulses for wake-up, start-of-frame and stop-of-frame, plus a level that says the CRC check passed.

Each timer has a 24-bit up-counter. An 8-bit prescaler gates how often the counter advances. When the count reaches the timer's programmed limit, a sticky timeout flag is raised. Software clears a flag by writing a one to it. The single interrupt line is the OR of the flags that software has enabled. All configuration goes through a simple write port: one address per timer holds the limit and the prescale value, one address clears flags, and one address holds the interrupt enables.

Top module: `frame_watch_timers`

## Requirements
- R1: After reset all three timeout flags are 0, `irq` is 0 and no timer is counting.
- R2: A write to address 0, 1 or 2 configures timer 0, 1 or 2. Bits [23:0] are the limit and bits [31:24] the prescale P. Once a timer is started, its flag rises exactly limit*(P+1) clock edges after the edge that sampled the start event.
- R3: A limit written as 0 or 1 is stored as 2, so the timeout then takes 2*(P+1) edges.
- R4: Timer 0 starts on `wake_evt`. A `sof_evt` that arrives before it times out stops it, and its flag stays 0.
- R5: Timer 1 starts on `sof_evt`. An `eof_evt` that arrives before it times out stops it, and its flag stays 0.
- R6: Timer 2 starts on `eof_evt` only while `crc_good` is 1. An `eof_evt` with `crc_good` at 0 leaves it idle.
- R7: A timeout flag stays at 1 until a write to address 3 has a 1 in that timer's bit (bit i for timer i). A 0 in that bit leaves it set. After expiring, a timer stops counting until it is started again.
- R8: A write to address 4 sets the interrupt enables, bit i for timer i. `irq` is 1 exactly when some flag and its enable are both 1.
- R9: A start event that arrives while a timer is counting restarts it from zero.
- R10: Writes to addresses 5, 6 and 7 change no flag, no enable and no timer setting.
- R11: When a timer's start event and its stop event arrive in the same cycle, the start wins and the timer counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| wake_evt | input | 1 | Wake-up event pulse |
| sof_evt | input | 1 | Start-of-frame detected pulse |
| eof_evt | input | 1 | Stop-of-frame detected pulse |
| crc_good | input | 1 | CRC-correct level, sampled with `eof_evt` |
| tmo_flag | output | 3 | Sticky timeout flags, bit i for timer i |
| irq | output | 1 | Interrupt request |

## Verification
The properties treat every event input as a synchronous pulse sampled at a rising edge. They treat a start or stop event as taking effect at that same edge, whatever else happens in the cycle. The exact-timing checks also assume that a timer's limit and prescale are not rewritten while it counts, because a smaller limit written mid-count would let the counter run past it. The stimulus therefore drives events and writes on the falling edge as one-cycle pulses. It writes a timer's configuration only before that timer is started, and it waits for the flag before it moves on to the next random case.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

   localparam int unsigned FWT_NUM       = 3;
   localparam int unsigned FWT_MIN_LIMIT = 2;

   localparam int unsigned FWT_TMR_WAKE  = 0;
   localparam int unsigned FWT_TMR_FRAME = 1;
   localparam int unsigned FWT_TMR_POST  = 2;

   localparam int unsigned FWT_ADDR_CLR  = 3;
   localparam int unsigned FWT_ADDR_IEN  = 4;

endpackage

// File: rtl/fwt_prescaler.sv
module fwt_prescaler #(
   parameter int unsigned PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             restart,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);

   logic [PSC_W-1:0] pcnt_q;

   // one tick every div+1 enabled cycles; restart realigns the phase
   assign tick = enable && !restart && (pcnt_q == div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (restart || !enable || tick) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/fwt_timer.sv
module fwt_timer #(
   parameter int unsigned CNT_W      = 24,
   parameter int unsigned PSC_W      = 8,
   parameter bit          HAS_CANCEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cancel,
   input  logic [CNT_W-1:0] limit,
   input  logic [PSC_W-1:0] psc,
   output logic             run,
   output logic             expire
);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             cancel_hit;
   logic             restart;
   logic             tick;
   logic             hit;

   assign cancel_hit = HAS_CANCEL & cancel & run_q;
   assign restart    = start | cancel_hit;
   assign cnt_inc    = cnt_q + 1'b1;
   assign hit        = tick && (cnt_inc == limit);

   fwt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (run_q),
      .restart (restart),
      .div     (psc),
      .tick    (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (cancel_hit) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_inc;
         if (hit) begin
            run_q <= 1'b0;
         end
      end
   end

   assign run    = run_q;
   assign expire = hit;

endmodule

// File: rtl/fwt_regs.sv
module fwt_regs
   import fwt_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NUM    = FWT_NUM
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [NUM-1:0]             expire,
   output logic [NUM-1:0][CNT_W-1:0]  limit,
   output logic [NUM-1:0][PSC_W-1:0]  psc,
   output logic [NUM-1:0]             ien,
   output logic [NUM-1:0]             flag
);

   localparam logic [CNT_W-1:0] LIMIT_FLOOR = CNT_W'(FWT_MIN_LIMIT);

   function automatic logic [CNT_W-1:0] floor_limit(input logic [CNT_W-1:0] v);
      return (v < LIMIT_FLOOR) ? LIMIT_FLOOR : v;
   endfunction

   logic [NUM-1:0] clr_mask;
   logic           ien_wr;

   assign clr_mask = (we && addr == ADDR_W'(FWT_ADDR_CLR)) ? wdata[NUM-1:0] : '0;
   assign ien_wr   = we && (addr == ADDR_W'(FWT_ADDR_IEN));

   for (genvar gi = 0; gi < NUM; gi++) begin : g_cfg
      logic sel;
      assign sel = we && (addr == ADDR_W'(gi));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            limit[gi] <= LIMIT_FLOOR;
            psc[gi]   <= '0;
         end else if (sel) begin
            limit[gi] <= floor_limit(wdata[CNT_W-1:0]);
            psc[gi]   <= wdata[CNT_W +: PSC_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien  <= '0;
         flag <= '0;
      end else begin
         if (ien_wr) begin
            ien <= wdata[NUM-1:0];
         end
         // a new expiry beats a clear in the same cycle
         flag <= (flag & ~clr_mask) | expire;
      end
   end

endmodule

// File: rtl/frame_watch_timers.sv
module frame_watch_timers
   import fwt_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              wake_evt,
   input  logic              sof_evt,
   input  logic              eof_evt,
   input  logic              crc_good,
   output logic [FWT_NUM-1:0] tmo_flag,
   output logic              irq
);

   localparam int unsigned NUM = FWT_NUM;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (PSC_W < 1) begin : g_bad_psc
      $error("PSC_W must be at least 1");
   end
   if (CNT_W + PSC_W > DATA_W) begin : g_bad_data
      $error("limit and prescale fields do not fit the write data");
   end
   if ((1 << ADDR_W) <= FWT_ADDR_IEN) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [NUM-1:0][CNT_W-1:0] limit;
   logic [NUM-1:0][PSC_W-1:0] psc;
   logic [NUM-1:0]            ien;
   logic [NUM-1:0]            t_start;
   logic [NUM-1:0]            t_cancel;
   logic [NUM-1:0]            tmr_run;
   logic [NUM-1:0]            tmr_expire;

   fwt_regs #(
      .CNT_W (CNT_W),
      .PSC_W (PSC_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .NUM   (NUM)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .expire(tmr_expire),
      .limit (limit),
      .psc   (psc),
      .ien   (ien),
      .flag  (tmo_flag)
   );

   for (genvar gi = 0; gi < NUM; gi++) begin : g_tmr
      if (gi == FWT_TMR_WAKE) begin : g_wake
         assign t_start[gi]  = wake_evt;
         assign t_cancel[gi] = sof_evt;
      end else if (gi == FWT_TMR_FRAME) begin : g_frame
         assign t_start[gi]  = sof_evt;
         assign t_cancel[gi] = eof_evt;
      end else begin : g_post
         assign t_start[gi]  = eof_evt & crc_good;
         assign t_cancel[gi] = 1'b0;
      end

      fwt_timer #(
         .CNT_W     (CNT_W),
         .PSC_W     (PSC_W),
         .HAS_CANCEL(gi != FWT_TMR_POST)
      ) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .start (t_start[gi]),
         .cancel(t_cancel[gi]),
         .limit (limit[gi]),
         .psc   (psc[gi]),
         .run   (tmr_run[gi]),
         .expire(tmr_expire[gi])
      );
   end

   assign irq = |(tmo_flag & ien);

endmodule

// File: rtl/fwt_checker.sv
module fwt_checker #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              wake_evt,
   input logic              sof_evt,
   input logic              eof_evt,
   input logic              crc_good,
   input logic [2:0]        tmo_flag,
   input logic              irq,
   input logic [2:0]        run
);

   logic [2:0] clr_req;
   assign clr_req = (cfg_we && cfg_addr == ADDR_W'(3)) ? cfg_wdata[2:0] : 3'b000;

   // R2
   flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((tmo_flag & ~$past(tmo_flag) & ~$past(run)) == 3'b000));

   // R4
   wake_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_evt && !wake_evt) |=> !run[0]);

   // R5
   frame_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_evt && !sof_evt) |=> !run[1]);

   // R6
   post_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_evt && crc_good) |=> run[2]);

   // R6
   post_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[2] && !(eof_evt && crc_good)) |=> !run[2]);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(tmo_flag) & ~$past(clr_req)) & ~tmo_flag) == 3'b000));

   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (tmo_flag != 3'b000));

   // R11
   wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> run[0]);

endmodule

bind frame_watch_timers fwt_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_fwt_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .wake_evt (wake_evt),
   .sof_evt  (sof_evt),
   .eof_evt  (eof_evt),
   .crc_good (crc_good),
   .tmo_flag (tmo_flag),
   .irq      (irq),
   .run      (tmr_run)
);

// File: tb/tb_frame_watch_timers.sv
module tb_frame_watch_timers;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        wake_evt, sof_evt, eof_evt, crc_good;
   logic [2:0]  tmo_flag;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   frame_watch_timers dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .wake_evt (wake_evt),
      .sof_evt  (sof_evt),
      .eof_evt  (eof_evt),
      .crc_good (crc_good),
      .tmo_flag (tmo_flag),
      .irq      (irq)
   );

   function automatic int exp_edges(input int lim, input int p);
      int l = (lim < 2) ? 2 : lim;
      return l * (p + 1);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_tmr(input int t, input int lim, input int p);
      wr(3'(t), {8'(p), 24'(lim)});
   endtask

   task automatic pulse(input logic w, input logic s, input logic e, input logic c);
      @(negedge clk);
      wake_evt = w; sof_evt = s; eof_evt = e; crc_good = c;
      @(negedge clk);
      wake_evt = 1'b0; sof_evt = 1'b0; eof_evt = 1'b0; crc_good = 1'b0;
   endtask

   // called right after pulse(): flag t must rise on exactly the n-th edge
   task automatic chk_timing(input int t, input int n, input string tag);
      repeat (n - 1) @(negedge clk);
      check({tag, " before limit"}, 32'(tmo_flag[t]), 32'd0);
      @(negedge clk);
      check({tag, " at limit"}, 32'(tmo_flag[t]), 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h5EED_1234;
      void'($urandom(seed));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      wake_evt = 1'b0; sof_evt = 1'b0; eof_evt = 1'b0; crc_good = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1
      check("R1 flags after reset", 32'(tmo_flag), 32'd0);
      check("R1 irq after reset", 32'(irq), 32'd0);

      // R2 exact timing with prescale
      cfg_tmr(0, 5, 2);
      pulse(1, 0, 0, 0);
      chk_timing(0, 15, "R2 timer0 5x3");

      // R7 write of zero keeps flag, write of one clears it
      wr(3'd3, 32'h0);
      check("R7 zero write keeps flag", 32'(tmo_flag[0]), 32'd1);
      wr(3'd3, 32'h1);
      check("R7 one write clears flag", 32'(tmo_flag[0]), 32'd0);
      repeat (50) @(negedge clk);
      check("R7 halted after timeout", 32'(tmo_flag[0]), 32'd0);

      // R3 clamp of 0 and 1
      cfg_tmr(1, 0, 0);
      pulse(0, 1, 0, 0);
      chk_timing(1, 2, "R3 limit 0");
      wr(3'd3, 32'h7);
      cfg_tmr(1, 1, 1);
      pulse(0, 1, 0, 0);
      chk_timing(1, 4, "R3 limit 1");
      wr(3'd3, 32'h7);

      // R4 / R5 / R6 cancellations and gated start
      cfg_tmr(0, 20, 0);
      cfg_tmr(1, 1000, 0);
      cfg_tmr(2, 3, 0);
      pulse(1, 0, 0, 0);
      repeat (5) @(negedge clk);
      pulse(0, 1, 0, 0);
      repeat (40) @(negedge clk);
      check("R4 sof cancels timer0", 32'(tmo_flag[0]), 32'd0);
      pulse(0, 0, 1, 0);
      repeat (1100) @(negedge clk);
      check("R5 eof cancels timer1", 32'(tmo_flag[1]), 32'd0);
      check("R6 eof without crc ignored", 32'(tmo_flag[2]), 32'd0);
      pulse(0, 0, 1, 1);
      chk_timing(2, 3, "R6 eof with crc");

      // R8 interrupt masking
      wr(3'd4, 32'h1);
      check("R8 masked flag no irq", 32'(irq), 32'd0);
      wr(3'd4, 32'h4);
      check("R8 enabled flag irq", 32'(irq), 32'd1);

      // R10 unmapped addresses
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'h0000_0000);
      check("R10 flags untouched", 32'(tmo_flag), 32'h4);
      check("R10 irq untouched", 32'(irq), 32'd1);
      wr(3'd3, 32'h7);
      check("R8 irq drops after clear", 32'(irq), 32'd0);
      pulse(0, 0, 1, 1);
      chk_timing(2, 3, "R10 timer2 setting kept");
      wr(3'd3, 32'h7);

      // R9 restart while counting
      cfg_tmr(0, 10, 0);
      pulse(1, 0, 0, 0);
      repeat (5) @(negedge clk);
      pulse(1, 0, 0, 0);
      chk_timing(0, 10, "R9 restart");
      wr(3'd3, 32'h7);

      // R11 start and cancel together
      cfg_tmr(0, 7, 1);
      pulse(1, 1, 0, 0);
      chk_timing(0, 14, "R11 start wins");
      wr(3'd3, 32'h7);

      // R2 / R3 random limits and prescales
      for (int it = 0; it < 24; it++) begin
         int t   = int'($urandom_range(2, 0));
         int lim = int'($urandom_range(30, 0));
         int p   = int'($urandom_range(3, 0));
         cfg_tmr(t, lim, p);
         wr(3'd3, 32'h7);
         if (t == 0)      pulse(1, 0, 0, 0);
         else if (t == 1) pulse(0, 1, 0, 0);
         else             pulse(0, 0, 1, 1);
         chk_timing(t, exp_edges(lim, p), "R2 random");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule